// File: doc/BRIEF.md
# Panel Trigger Interrupt Generator

This block produces the trigger interrupt that paces frame updates toward a command-driven LCD panel. It holds one 32-bit configuration word, loaded over a single-cycle write strobe and always visible on a readback bus. The word carries two counter factors and a two-bit mode selector. The block runs on the panel data clock.

In periodic mode the interrupt is timed by a chain of three wrapping counters: a fixed divide-by-four prescaler, an inner counter with limit M, and an outer counter with limit N. The interrupt fires once every (N+1)·(M+1)·4 clocks. In the two tearing-effect modes the counters are held at zero. The interrupt then follows the panel's tearing-effect line, which is first passed through a two-flop synchronizer. One mode fires on its rising edge and the other on its falling edge. With the mode set to off, nothing fires.

Software writes the word once to choose a pacing source. Any write restarts the periodic timer from zero.

Top module: `panel_trig_gen`

## Requirements
- R1: After a synchronous reset, the readback is 0x00000000, the mode is off and `trig_irq` is low.
- R2: A write stores M from bits 7:0, N from bits 23:8 and the mode from bits 29:28. The readback shows those fields in the same positions. Bits 31:30 and 27:24 read as zero, whatever was written.
- R3: With mode code 0 (off), `trig_irq` stays low.
- R4: With mode code 1 (periodic), `trig_irq` pulses every (N+1)·(M+1)·4 clocks. The first pulse rises on the clock edge exactly (N+1)·(M+1)·4 edges after the write edge.
- R5: Every `trig_irq` pulse is exactly one clock wide.
- R6: With M=0 and N=0 in periodic mode, the period is 4 clocks, the shortest the block produces.
- R7: With mode code 2, each rising edge of `te_pin` gives one pulse. The pulse is high after the third rising clock edge following the `te_pin` change. Falling edges give nothing.
- R8: With mode code 3, each falling edge of `te_pin` gives one pulse with the same latency as in R7. Rising edges give nothing.
- R9: In modes 0 and 1, `te_pin` has no effect on `trig_irq`.
- R10: Any write clears the periodic counters. A write in the middle of a period suppresses the pending pulse, and the next pulse comes a full period after the new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Panel data clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to be written |
| cfg_rdata | output | 32 | Readback of the stored configuration word |
| te_pin | input | 1 | Asynchronous tearing-effect input from the panel |
| trig_irq | output | 1 | One-clock trigger interrupt pulse |

## Verification
The bench measures the position of the first pulse after a write, counted in clock edges. An off-by-one in the prescaler or in either limit compare shifts that position, and nested factors such as M=4, N=3 expose it as a period that is off by a multiple. Rewriting the configuration in the middle of a period catches counters that are not cleared on a write: such a design fires early, or lets the stale pulse through. The tearing-effect input is toggled while the mode is off or periodic, and driven with both edge polarities in the two edge modes. A design that ignores the mode gate, detects the wrong polarity, or has a wrong synchronizer depth gives extra pulses, missing pulses or a shifted pulse. Every pulse is also checked to be one clock wide.

// File: rtl/panel_trig_pkg.sv
package panel_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF      = 2'd0,
    TRIG_PERIODIC = 2'd1,
    TRIG_TE_RISE  = 2'd2,
    TRIG_TE_FALL  = 2'd3
  } trig_mode_e;

  localparam int unsigned CFG_DATA_W   = 32;
  localparam int unsigned CFG_MODE_LSB = 28;
  localparam int unsigned CFG_MODE_W   = 2;

endpackage

// File: rtl/ptg_cfg_reg.sv
module ptg_cfg_reg
  import panel_trig_pkg::*;
#(
  parameter int unsigned M_W    = 8,
  parameter int unsigned N_W    = 16,
  parameter int unsigned DATA_W = CFG_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [M_W-1:0]    m_lim,
  output logic [N_W-1:0]    n_lim,
  output trig_mode_e        mode,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned N_LSB = M_W;

  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  trig_mode_e     mode_q;
  logic           unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q    <= '0;
      n_q    <= '0;
      mode_q <= TRIG_OFF;
    end else if (we) begin
      m_q    <= wdata[M_W-1:0];
      n_q    <= wdata[N_LSB +: N_W];
      mode_q <= trig_mode_e'(wdata[CFG_MODE_LSB +: CFG_MODE_W]);
    end
  end

  always_comb begin
    rdata                                = '0;
    rdata[M_W-1:0]                       = m_q;
    rdata[N_LSB +: N_W]                  = n_q;
    rdata[CFG_MODE_LSB +: CFG_MODE_W]    = mode_q;
  end

  assign m_lim = m_q;
  assign n_lim = n_q;
  assign mode  = mode_q;

  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata[M_W-1:0] == $past(wdata[M_W-1:0])) &&
           (rdata[N_LSB +: N_W] == $past(wdata[N_LSB +: N_W])) &&
           (rdata[CFG_MODE_LSB +: CFG_MODE_W] == $past(wdata[CFG_MODE_LSB +: CFG_MODE_W])))
    else $error("write not captured"); // R2

endmodule

// File: rtl/ptg_period_cnt.sv
module ptg_period_cnt #(
  parameter int unsigned M_W   = 8,
  parameter int unsigned N_W   = 16,
  parameter int unsigned PRE_W = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic [M_W-1:0] m_lim,
  input  logic [N_W-1:0] n_lim,
  output logic           wrap_all
);

  logic [PRE_W-1:0] pre_q;
  logic [M_W-1:0]   inner_q;
  logic [N_W-1:0]   outer_q;
  logic             pre_wrap;
  logic             inner_wrap;
  logic             outer_wrap;

  assign pre_wrap   = (pre_q == {PRE_W{1'b1}});
  assign inner_wrap = (inner_q == m_lim);
  assign outer_wrap = (outer_q == n_lim);
  assign wrap_all   = pre_wrap && inner_wrap && outer_wrap;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      inner_q <= '0;
    end else if (pre_wrap) begin
      inner_q <= inner_wrap ? '0 : inner_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      outer_q <= '0;
    end else if (pre_wrap && inner_wrap) begin
      outer_q <= outer_wrap ? '0 : outer_q + 1'b1;
    end
  end

  AST_INNER_BOUND: assert property (@(posedge clk) disable iff (rst)
    inner_q <= m_lim)
    else $error("inner counter beyond M"); // R4

  AST_OUTER_BOUND: assert property (@(posedge clk) disable iff (rst)
    outer_q <= n_lim)
    else $error("outer counter beyond N"); // R4

endmodule

// File: rtl/ptg_te_edge.sv
module ptg_te_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic te_in,
  output logic te_rise,
  output logic te_fall
);

  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= 1'b0;
    else     pipe_q[0] <= te_in;
  end

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe_q[s] <= 1'b0;
      else     pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign te_rise = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign te_fall = ~pipe_q[SYNC_STAGES-1] & pipe_q[SYNC_STAGES];

endmodule

// File: rtl/panel_trig_gen.sv
module panel_trig_gen
  import panel_trig_pkg::*;
#(
  parameter int unsigned M_W         = 8,
  parameter int unsigned N_W         = 16,
  parameter int unsigned PRE_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_DATA_W-1:0] cfg_wdata,
  output logic [CFG_DATA_W-1:0] cfg_rdata,
  input  logic                  te_pin,
  output logic                  trig_irq
);

  logic [M_W-1:0] m_lim;
  logic [N_W-1:0] n_lim;
  trig_mode_e     mode;
  logic           cnt_clear;
  logic           wrap_all;
  logic           te_rise;
  logic           te_fall;
  logic           irq_q;

  ptg_cfg_reg #(.M_W(M_W), .N_W(N_W), .DATA_W(CFG_DATA_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .m_lim (m_lim),
    .n_lim (n_lim),
    .mode  (mode),
    .rdata (cfg_rdata)
  );

  assign cnt_clear = cfg_we || (mode != TRIG_PERIODIC);

  ptg_period_cnt #(.M_W(M_W), .N_W(N_W), .PRE_W(PRE_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (cnt_clear),
    .m_lim    (m_lim),
    .n_lim    (n_lim),
    .wrap_all (wrap_all)
  );

  ptg_te_edge #(.SYNC_STAGES(SYNC_STAGES)) u_te (
    .clk     (clk),
    .rst     (rst),
    .te_in   (te_pin),
    .te_rise (te_rise),
    .te_fall (te_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      case (mode)
        TRIG_PERIODIC: irq_q <= wrap_all && !cfg_we;
        TRIG_TE_RISE:  irq_q <= te_rise;
        TRIG_TE_FALL:  irq_q <= te_fall;
        default:       irq_q <= 1'b0;
      endcase
    end
  end

  assign trig_irq = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trig_irq |=> !trig_irq)
    else $error("interrupt wider than one clock"); // R5

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(mode == TRIG_OFF) |-> !trig_irq)
    else $error("interrupt while off"); // R3

endmodule

// File: tb/panel_trig_gen_test.sv
`timescale 1ns/1ps
module panel_trig_gen_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        te_pin;
  logic        trig_irq;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  panel_trig_gen uut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .te_pin    (te_pin),
    .trig_irq  (trig_irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic measure(input int len, input bit toggle,
                         output int first, output int count, output int maxw);
    int run = 0;
    first = -1; count = 0; maxw = 0;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (trig_irq) begin
        if (run == 0) begin
          count++;
          if (first < 0) first = i;
        end
        run++;
        if (run > maxw) maxw = run;
      end else begin
        run = 0;
      end
      if (toggle && (i % 3 == 0)) te_pin = ~te_pin;
    end
  endtask

  task automatic t_reset();
    check(cfg_rdata == 32'h0, "R1 readback", cfg_rdata, 0);
    check(trig_irq == 1'b0, "R1 irq", trig_irq, 0);
  endtask

  task automatic t_readback();
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h30FF_FFFF, "R2 all ones", cfg_rdata, 32'h30FF_FFFF);
    write_cfg(32'h1234_5678);
    check(cfg_rdata == 32'h1034_5678, "R2 mixed", cfg_rdata, 32'h1034_5678);
  endtask

  task automatic t_off();
    int f, c, w;
    write_cfg(32'h0000_0000);
    measure(60, 1'b1, f, c, w);
    check(c == 0, "R3 R9 off with TE toggling", c, 0);
  endtask

  task automatic t_period(input logic [7:0] m, input logic [15:0] n, input int len, input string req);
    int f, c, w, p;
    p = (int'(n) + 1) * (int'(m) + 1) * 4;
    write_cfg({4'h1, 4'h0, n, m});
    measure(len, 1'b0, f, c, w);
    check(f == p, {req, " first pulse"}, f, p);
    check(c == len / p, {req, " pulse count"}, c, len / p);
    check(w == 1, "R5 width", w, 1);
  endtask

  task automatic t_restart();
    int f, c, w;
    write_cfg(32'h1000_0102);
    measure(10, 1'b0, f, c, w);
    check(c == 0, "R10 no early pulse", c, 0);
    write_cfg(32'h1000_0102);
    measure(60, 1'b0, f, c, w);
    check(f == 24, "R10 restart first pulse", f, 24);
  endtask

  task automatic t_te_ignored_periodic();
    int f, c, w;
    write_cfg(32'h1000_0000);
    measure(40, 1'b1, f, c, w);
    check(f == 4 && c == 10, "R9 periodic with TE toggling", c, 10);
  endtask

  task automatic t_te_rise();
    int f, c, w;
    te_pin = 1'b0;
    write_cfg(32'h2000_0000);
    measure(6, 1'b0, f, c, w);
    check(c == 0, "R7 settle", c, 0);
    te_pin = 1'b1;
    measure(10, 1'b0, f, c, w);
    check(f == 3 && c == 1, "R7 rising latency", f, 3);
    check(w == 1, "R5 TE width", w, 1);
    te_pin = 1'b0;
    measure(10, 1'b0, f, c, w);
    check(c == 0, "R7 falling ignored", c, 0);
  endtask

  task automatic t_te_fall();
    int f, c, w;
    write_cfg(32'h3000_0000);
    measure(6, 1'b0, f, c, w);
    te_pin = 1'b1;
    measure(10, 1'b0, f, c, w);
    check(c == 0, "R8 rising ignored", c, 0);
    te_pin = 1'b0;
    measure(10, 1'b0, f, c, w);
    check(f == 3 && c == 1, "R8 falling latency", f, 3);
  endtask

  initial begin
    #(100000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; te_pin = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_off();
    t_period(8'd2, 16'd1, 100, "R4 M2 N1");
    t_period(8'd0, 16'd0, 40, "R6 minimum");
    t_period(8'd4, 16'd3, 200, "R4 M4 N3");
    t_restart();
    t_te_ignored_periodic();
    t_te_rise();
    t_te_fall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule